// File: doc/BRIEF.md
# USB Line-State Clock Recovery

This block takes the raw, asynchronous D+ and D- receiver pins of a USB port and turns them into a stream of decoded line states, one per bit period. It is clocked at four times the bit rate. First it brings both pins into the local clock domain. Then it removes single-sample corruption with a per-pin three-sample majority. Finally it follows the bit phase by realigning a small phase counter on every line transition. At the middle of each bit it reports which of the four pair states was on the wire.

The output is a one-cycle valid strobe together with four one-hot state flags. Downstream NRZI decoding, bit unstuffing and packet framing consume these flags; none of that is part of this block. Between edges the phase counter keeps running. Long runs of one state therefore still produce one symbol per bit.

Top module: `usb_line_recover`

## Requirements
- R1: With the pair written as {D+, D-}, 2'b10 is reported on `j_o`, 2'b01 on `k_o`, 2'b00 on `se0_o` and 2'b11 on `se1_o`. When `valid_o` is high exactly one flag is high, and when it is low all four flags are low.
- R2: For a stream of bits that are four samples long, the symbols reported with `valid_o` equal the driven symbols in order, with none missing and none repeated.
- R3: Corrupting any single sample among the first 32 samples of a stream, on one pin or on both, leaves the reported symbol sequence unchanged.
- R4: A long run of one unchanged line state yields exactly one symbol per four-sample bit.
- R5: Rapid alternation between states, and arbitrary mixes of all four states, are recovered symbol for symbol.
- R6: During reset and after its release, `valid_o` and all flags stay low until the line has settled and a transition has been seen. A steady idle line produces no symbols.
- R7: When every bit differs from the one before it, bits lasting three or five samples are each recovered exactly once, because the phase realigns on each transition.
- R8: Two strobes on `valid_o` are always separated by at least two idle cycles. Once strobes have begun, the gap between two strobes never exceeds six cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock at four times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | Raw D+ pin, asynchronous |
| dn_i | input | 1 | Raw D- pin, asynchronous |
| valid_o | output | 1 | One-cycle strobe per recovered bit |
| j_o | output | 1 | Recovered bit is J |
| k_o | output | 1 | Recovered bit is K |
| se0_o | output | 1 | Recovered bit is SE0 |
| se1_o | output | 1 | Recovered bit is SE1 |

## Verification
The bench builds the block with its default values: an oversampling ratio of four and a two-stage synchroniser. With a four-sample bit, a sweep of the corruption point over the first 32 samples lands on every phase position, including both bit boundaries, several times. Drawing bit lengths from three to five samples exercises the phase realignment at both ends of the allowed drift. Random mixes of states and one-pin or two-pin corruption masks reach the cases where the two pins move on different samples.

// File: rtl/usb_lsr_pkg.sv
package usb_lsr_pkg;
  // pair encoding is {dp, dn}
  typedef logic [1:0] pair_t;
  localparam pair_t PAIR_SE0 = 2'b00;
  localparam pair_t PAIR_K   = 2'b01;
  localparam pair_t PAIR_J   = 2'b10;
  localparam pair_t PAIR_SE1 = 2'b11;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsr_median3.sv
module lsr_median3 #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] h0_q, h1_q, h2_q;
  logic [WIDTH-1:0] vote;

  // per-pin two-of-three over consecutive samples
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign vote[b] = (h0_q[b] & h1_q[b]) | (h1_q[b] & h2_q[b]) | (h0_q[b] & h2_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0;
      h1_q <= '0;
      h2_q <= '0;
      q_o  <= '0;
    end else begin
      h0_q <= d_i;
      h1_q <= h0_q;
      h2_q <= h1_q;
      q_o  <= vote;
    end
  end
endmodule

// File: rtl/lsr_phase.sv
module lsr_phase
  import usb_lsr_pkg::*;
#(
  parameter int OVERSAMPLE = 4,
  parameter int SETTLE     = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pair_t line_i,
  output logic  fire_o,
  output pair_t sym_o
);
  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2;
  localparam int CNT_W = $clog2(SETTLE + 1);

  pair_t            prev_q;
  logic [PH_W-1:0]  ph_q, pos;
  logic [CNT_W-1:0] settle_q;
  logic             armed_q, edge_w, settled;

  assign edge_w  = line_i != prev_q;
  assign pos     = edge_w ? '0 : ph_q;   // transition restarts the bit
  assign settled = settle_q == CNT_W'(SETTLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= PAIR_SE0;
      ph_q     <= '0;
      settle_q <= '0;
      armed_q  <= 1'b0;
      fire_o   <= 1'b0;
      sym_o    <= PAIR_SE0;
    end else begin
      prev_q <= line_i;
      ph_q   <= (pos == PH_W'(OVERSAMPLE - 1)) ? '0 : pos + PH_W'(1);
      if (!settled) settle_q <= settle_q + CNT_W'(1);
      if (edge_w && settled) armed_q <= 1'b1;
      fire_o <= armed_q && (pos == PH_W'(MID));
      sym_o  <= line_i;
    end
  end
endmodule

// File: rtl/usb_line_recover.sv
module usb_line_recover
  import usb_lsr_pkg::*;
#(
  parameter int OVERSAMPLE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dn_i,
  output logic valid_o,
  output logic j_o,
  output logic k_o,
  output logic se0_o,
  output logic se1_o
);
  // covers reset-value to idle propagation through sync and filter
  localparam int SETTLE = SYNC_STAGES + 6;

  pair_t sync_w, filt_w, sym_w;
  logic  fire_w;

  lsr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_i, dn_i}),
    .q_o   (sync_w)
  );

  lsr_median3 #(.WIDTH(2)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_w),
    .q_o   (filt_w)
  );

  lsr_phase #(.OVERSAMPLE(OVERSAMPLE), .SETTLE(SETTLE)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(filt_w),
    .fire_o(fire_w),
    .sym_o (sym_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      j_o     <= 1'b0;
      k_o     <= 1'b0;
      se0_o   <= 1'b0;
      se1_o   <= 1'b0;
    end else begin
      valid_o <= fire_w;
      j_o     <= fire_w && (sym_w == PAIR_J);
      k_o     <= fire_w && (sym_w == PAIR_K);
      se0_o   <= fire_w && (sym_w == PAIR_SE0);
      se1_o   <= fire_w && (sym_w == PAIR_SE1);
    end
  end
endmodule

// File: rtl/usb_line_recover_chk.sv
module usb_line_recover_chk #(
  parameter int OVERSAMPLE = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic j_i,
  input logic k_i,
  input logic se0_i,
  input logic se1_i
);
  localparam int MAX_GAP = OVERSAMPLE + 2;

  logic [3:0] flags;
  logic [7:0] gap_q;
  logic [1:0] age_q;
  logic       seen_q;

  assign flags = {j_i, k_i, se0_i, se1_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (valid_i) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != 8'hff) begin
        gap_q <= gap_q + 8'd1;
      end
    end
  end

  // R1
  valid_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $countones(flags) == 1);

  // R1
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> flags == 4'b0000);

  // R8
  strobe_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i ##1 !valid_i);

  // R8
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> gap_q <= 8'(MAX_GAP));

  // R6
  early_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q != 2'd3 |-> !valid_i);
endmodule

bind usb_line_recover usb_line_recover_chk #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_o),
  .j_i    (j_o),
  .k_i    (k_o),
  .se0_i  (se0_o),
  .se1_i  (se1_o)
);

// File: tb/sim_usb_line_recover.sv
`timescale 1ns/1ps
module sim_usb_line_recover;
  import usb_lsr_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dp = 1'b0, dn = 1'b0;
  logic valid_o, j_o, k_o, se0_o, se1_o;

  always #4 clk = ~clk;  // 125 MHz

  usb_line_recover u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dp_i(dp), .dn_i(dn),
    .valid_o(valid_o), .j_o(j_o), .k_o(k_o), .se0_o(se0_o), .se1_o(se1_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  pair_t seq [64];
  int    blen[64];
  int    n_sym;
  int    glitch;
  pair_t gmask;

  pair_t got [80];
  int    got_n;
  int    early_n;
  int    bad_n;
  bit    mon_en;
  bit    streaming;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && mon_en) begin
      if (valid_o) begin
        if (!streaming) early_n++;
        else if (got_n < 80) begin
          case ({j_o, k_o, se0_o, se1_o})
            4'b1000: got[got_n] = PAIR_J;
            4'b0100: got[got_n] = PAIR_K;
            4'b0010: got[got_n] = PAIR_SE0;
            4'b0001: got[got_n] = PAIR_SE1;
            default: begin got[got_n] = PAIR_SE0; bad_n++; end
          endcase
          got_n++;
        end
      end else if ({j_o, k_o, se0_o, se1_o} != 4'b0000) begin
        bad_n++;
      end
    end
  end

  function automatic pair_t ch2p(byte c);
    case (c)
      "j": return PAIR_J;
      "k": return PAIR_K;
      "1": return PAIR_SE1;
      default: return PAIR_SE0;
    endcase
  endfunction

  task automatic load_str(string s);
    n_sym = s.len();
    for (int i = 0; i < n_sym; i++) begin
      seq[i]  = ch2p(s[i]);
      blen[i] = 4;
    end
  endtask

  task automatic load_rand(int n, bit alternate, bit drift);
    n_sym = n;
    for (int i = 0; i < n; i++) begin
      seq[i] = pair_t'($urandom_range(3, 0));
      if (alternate && i > 0 && seq[i] == seq[i-1])
        seq[i] = seq[i-1] ^ pair_t'($urandom_range(3, 1));
      blen[i] = drift ? int'($urandom_range(5, 3)) : 4;
    end
  endtask

  task automatic run_case(string rq, string what);
    pair_t idle;
    int    samp;
    bit    ok;
    int    first_bad;
    idle = seq[0] ^ 2'b11;
    rst_ni = 1'b0;
    mon_en = 1'b0;
    streaming = 1'b0;
    got_n = 0; early_n = 0; bad_n = 0;
    {dp, dn} = idle;
    repeat (3) @(negedge clk);
    chk({valid_o, j_o, k_o, se0_o, se1_o} == 5'b0, "R6", "outputs in reset",
        int'({valid_o, j_o, k_o, se0_o, se1_o}), 0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    repeat (14) @(negedge clk);
    streaming = 1'b1;
    samp = 0;
    for (int b = 0; b < n_sym; b++) begin
      for (int s = 0; s < blen[b]; s++) begin
        {dp, dn} = (samp == glitch) ? (seq[b] ^ gmask) : seq[b];
        samp++;
        @(negedge clk);
      end
    end
    {dp, dn} = seq[n_sym-1];
    repeat (16) @(negedge clk);
    mon_en = 1'b0;
    chk(early_n == 0, "R6", {what, " symbols before stream"}, early_n, 0);
    chk(bad_n == 0, "R1", {what, " flag encoding"}, bad_n, 0);
    ok = got_n >= n_sym;
    first_bad = -1;
    for (int i = 0; i < got_n && i < 80; i++) begin
      if (got[i] != ((i < n_sym) ? seq[i] : seq[n_sym-1])) begin
        if (first_bad < 0) first_bad = i;
        ok = 1'b0;
      end
    end
    if (first_bad >= 0)
      chk(ok, rq, {what, " symbol at first mismatch"}, int'(got[first_bad]),
          int'((first_bad < n_sym) ? seq[first_bad] : seq[n_sym-1]));
    else
      chk(ok, rq, {what, " symbol count"}, got_n, n_sym);
    @(negedge clk);
  endtask

  initial begin
    glitch = -1;
    gmask  = 2'b00;
    void'($urandom(32'd20240611));

    // R1 each state alone
    load_str("j");    run_case("R1", "single j");
    load_str("k");    run_case("R1", "single k");
    load_str("0");    run_case("R1", "single se0");
    load_str("1");    run_case("R1", "single se1");
    load_str("jk01"); run_case("R2", "four states");
    // R4 long runs
    load_str("kjjjjjjjjjjjjjjjjjjjjk"); run_case("R4", "long j run");
    load_str("100000000000000000001");  run_case("R4", "long se0 run");
    // R5 rapid alternation
    load_str("jkjkjkjkjkjkjkjk01010101"); run_case("R5", "alternation");
    for (int r = 0; r < 12; r++) begin
      load_rand(24, 1'b0, 1'b0);
      run_case("R5", "random mix");
    end
    // R3 glitch sweep over first 32 samples
    load_rand(40, 1'b0, 1'b0);
    for (int g = 0; g < 32; g++) begin
      glitch = g;
      gmask  = pair_t'((g % 3) + 1);
      run_case("R3", "glitch sweep");
    end
    for (int r = 0; r < 16; r++) begin
      load_rand(30, 1'b0, 1'b0);
      glitch = int'($urandom_range(31, 0));
      gmask  = pair_t'($urandom_range(3, 1));
      run_case("R3", "random glitch");
    end
    glitch = -1;
    // R7 drifting bit lengths with an edge every bit
    for (int r = 0; r < 10; r++) begin
      load_rand(30, 1'b1, 1'b1);
      run_case("R7", "drift");
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule